// File: doc/BRIEF.md
# Operand Effective Address Generator

This block works out where an instruction operand lives, for a 16-bit processor whose sixteen general registers are not flip-flops but consecutive words in main memory, starting at the address held in a workspace base register. The decode stage hands it a 2-bit addressing mode, a 4-bit register number, a flag that marks a byte-sized operand, the extension word that follows the instruction (if any) and the current workspace base. It then reports one of two things. The first is that the operand is the register word itself, in which case the address returned is that word's location. The second is the memory address of the operand.

Modes that dereference a register read the register word through a single shared memory port. The auto-increment mode then writes the bumped register value back through the same port before it reports completion. The instruction fetch logic watches an output that says whether the extension word was consumed, and advances its program counter to match. The execute stage performs the actual operand transfer once the block pulses `done`.

The mode codes are 00 register, 01 register-indirect, 10 indexed and 11 indirect with auto-increment. `byte_op` = 1 selects a byte operand and 0 a word operand. Register n sits at address `wp + 2*n`.

Top module: `opaddr_gen`

## Requirements
- R1: Mode 00 performs no memory access. `done` rises in the first cycle after `start` is sampled, with `is_reg`=1, `ext_used`=0 and `ea` = (`wp` + 2·`reg_num`) mod 2^16.
- R2: Mode 01 reads the register word at `wp`+2·`reg_num` and writes nothing. `done` rises three cycles after `start` is sampled, with `ea` equal to the word read, `is_reg`=0 and `ext_used`=0.
- R3: Mode 10 with a nonzero register number reads that register and writes nothing. `done` rises three cycles after `start` is sampled, with `ea` = (`ext_word` + register word) mod 2^16, `ext_used`=1 and `is_reg`=0.
- R4: Mode 10 with register number 0 performs no memory access. `done` rises one cycle after `start` is sampled, with `ea` = `ext_word`, `ext_used`=1 and `is_reg`=0.
- R5: Mode 11 reads the register word and reports `ea` equal to the value read. In the cycle just before `done` it writes back to the same register address the value read plus 2 (`byte_op`=0) or plus 1 (`byte_op`=1). `done` rises four cycles after `start` is sampled, with `is_reg`=0 and `ext_used`=0. Mode 11 is the only mode that writes.
- R6: All address sums wrap modulo 2^16. This covers the register location, the indexed sum and the incremented register value.
- R7: `busy` is high while a memory-based computation is in progress. A `start` seen while `busy` is high is ignored: it produces no extra `done` and no memory access, and it leaves the result of the running computation unchanged. `mem_req` is low whenever `busy` is low.
- R8: After reset, `done`, `busy` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a computation with the operand fields below |
| mode | input | 2 | Addressing mode (00 reg, 01 indirect, 10 indexed, 11 auto-increment) |
| reg_num | input | 4 | General register number |
| byte_op | input | 1 | 1 = byte operand, 0 = word operand |
| ext_word | input | 16 | Extension word following the instruction |
| wp | input | 16 | Workspace base address |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse: `ea`, `is_reg` and `ext_used` are valid |
| is_reg | output | 1 | Operand is the register word itself |
| ea | output | 16 | Effective address |
| ext_used | output | 1 | Extension word was consumed |
| mem_req | output | 1 | Memory port request |
| mem_we | output | 1 | Memory port write enable |
| mem_addr | output | 16 | Memory port byte address |
| mem_wdata | output | 16 | Memory port write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |

## Verification
A corrupted latched register address shows up in the same operation, either at `mem_addr` during the read or as a wrong `ea` on the `done` cycle. A wrong saved increment value surfaces as bad write data one cycle before `done`, and in the workspace memory afterwards. A sequencer stuck in or skipping a state moves the `done` pulse away from its fixed 1, 3 or 4 cycle latency, or makes a write appear in a mode other than 11. The bench therefore checks the cycle of every `done`, the result fields and the read and write counts seen at the memory port.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;

    typedef enum logic [1:0] {
        AM_REG  = 2'b00,
        AM_IND  = 2'b01,
        AM_IDX  = 2'b10,
        AM_AUTO = 2'b11
    } amode_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'b00,
        S_RD   = 2'b01,
        S_WAIT = 2'b10,
        S_WB   = 2'b11
    } gstate_t;

endpackage

// File: rtl/opaddr_regloc.sv
module opaddr_regloc #(
    parameter int AW = 16,
    parameter int RW = 4
) (
    input  logic [AW-1:0] base,
    input  logic [RW-1:0] rnum,
    output logic [AW-1:0] loc
);
    localparam int PADW = AW - RW - 1;

    logic [AW-1:0] offset;

    // each register is one word, two bytes apart
    assign offset = {{PADW{1'b0}}, rnum, 1'b0};
    assign loc    = base + offset;
endmodule

// File: rtl/opaddr_arith.sv
module opaddr_arith #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] content,
    input  logic [AW-1:0] disp,
    input  logic          use_disp,
    input  logic          byte_sz,
    output logic [AW-1:0] eff,
    output logic [AW-1:0] bumped
);
    localparam logic [AW-1:0] STEP_BYTE = AW'(1);
    localparam logic [AW-1:0] STEP_WORD = AW'(2);

    logic [AW-1:0] addend;

    always_comb begin
        addend = use_disp ? disp : '0;
        eff    = content + addend;
        bumped = content + (byte_sz ? STEP_BYTE : STEP_WORD);
    end
endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen
    import opaddr_pkg::*;
#(
    parameter int AW   = 16,
    parameter int NREG = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    mode,
    input  logic [3:0]    reg_num,
    input  logic          byte_op,
    input  logic [15:0]   ext_word,
    input  logic [15:0]   wp,
    output logic          busy,
    output logic          done,
    output logic          is_reg,
    output logic [15:0]   ea,
    output logic          ext_used,
    output logic          mem_req,
    output logic          mem_we,
    output logic [15:0]   mem_addr,
    output logic [15:0]   mem_wdata,
    input  logic [15:0]   mem_rdata
);
    localparam int RW = $clog2(NREG);

    typedef struct packed {
        gstate_t       st;
        amode_t        md;
        logic          done;
        logic          is_reg;
        logic          ext_used;
        logic [AW-1:0] ea;
        logic [AW-1:0] ext;
        logic [AW-1:0] raddr;
        logic [AW-1:0] wbval;
    } gen_t;

    gen_t q, d;

    logic [AW-1:0] loc_now;
    logic [AW-1:0] eff_calc;
    logic [AW-1:0] bump_calc;
    logic          byte_q;

    opaddr_regloc #(.AW(AW), .RW(RW)) u_loc (
        .base (wp),
        .rnum (reg_num[RW-1:0]),
        .loc  (loc_now)
    );

    opaddr_arith #(.AW(AW)) u_arith (
        .content  (mem_rdata),
        .disp     (q.ext),
        .use_disp (q.md == AM_IDX),
        .byte_sz  (byte_q),
        .eff      (eff_calc),
        .bumped   (bump_calc)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.md       = amode_t'(mode);
                    d.ext      = ext_word;
                    d.raddr    = loc_now;
                    d.ext_used = (amode_t'(mode) == AM_IDX);
                    d.is_reg   = (amode_t'(mode) == AM_REG);
                    if (amode_t'(mode) == AM_REG) begin
                        d.ea   = loc_now;
                        d.done = 1'b1;
                    end else if (amode_t'(mode) == AM_IDX && reg_num == '0) begin
                        d.ea   = ext_word;
                        d.done = 1'b1;
                    end else begin
                        d.st   = S_RD;
                    end
                end
            end
            S_RD: begin
                d.st = S_WAIT;
            end
            S_WAIT: begin
                d.ea    = eff_calc;
                d.wbval = bump_calc;
                if (q.md == AM_AUTO) begin
                    d.st   = S_WB;
                end else begin
                    d.st   = S_IDLE;
                    d.done = 1'b1;
                end
            end
            S_WB: begin
                d.st   = S_IDLE;
                d.done = 1'b1;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            byte_q <= 1'b0;
        end else begin
            q <= d;
            if (q.st == S_IDLE && start) byte_q <= byte_op;
        end
    end

    assign busy      = (q.st != S_IDLE);
    assign done      = q.done;
    assign is_reg    = q.is_reg;
    assign ea        = q.ea;
    assign ext_used  = q.ext_used;
    assign mem_req   = (q.st == S_RD) || (q.st == S_WB);
    assign mem_we    = (q.st == S_WB);
    assign mem_addr  = q.raddr;
    assign mem_wdata = q.wbval;

    AST_DIRECT_NO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        done && is_reg |-> !ext_used); // R1
    AST_READ_THEN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we |=> busy && !mem_req); // R2
    AST_EXT_NOT_REG: assert property (@(posedge clk) disable iff (!rst_n)
        done && ext_used |-> !is_reg); // R3
    AST_WB_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |=> done); // R5
    AST_WB_ONLY_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> q.md == AM_AUTO); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req); // R7
    AST_WB_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_addr == $past(mem_addr, 2)); // R5
endmodule

// File: tb/opaddr_gen_test.sv
module opaddr_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  mode = '0;
    logic [3:0]  reg_num = '0;
    logic        byte_op = 1'b0;
    logic [15:0] ext_word = '0;
    logic [15:0] wp = '0;
    logic        busy, done, is_reg, ext_used, mem_req, mem_we;
    logic [15:0] ea, mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;

    always #2 clk = ~clk;

    opaddr_gen uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .reg_num(reg_num),
        .byte_op(byte_op), .ext_word(ext_word), .wp(wp), .busy(busy), .done(done),
        .is_reg(is_reg), .ea(ea), .ext_used(ext_used), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    logic [15:0] mem [256];
    int ncyc = 0;
    int nrd = 0;
    int nwr = 0;
    int checks = 0;
    int fails = 0;
    int extra_done = 0;

    typedef struct {
        logic [15:0] ea;
        logic        is_reg;
        logic        ext_used;
        int          cyc;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always @(posedge clk) begin
        ncyc <= ncyc + 1;
        if (mem_req && mem_we) begin
            mem[mem_addr[8:1]] <= mem_wdata;
            nwr <= nwr + 1;
        end else if (mem_req) begin
            mem_rdata <= mem[mem_addr[8:1]];
            nrd <= nrd + 1;
        end
    end

    task automatic chk(input logic ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // monitor: compares each done against the scoreboard head
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                extra_done++;
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(ea == e.ea, e.tag, "ea", int'(ea), int'(e.ea));
                chk(is_reg == e.is_reg, e.tag, "is_reg", int'(is_reg), int'(e.is_reg));
                chk(ext_used == e.ext_used, e.tag, "ext_used", int'(ext_used), int'(e.ext_used));
                chk(ncyc == e.cyc, e.tag, "done cycle", ncyc, e.cyc);
            end
        end
    end

    task automatic run_op(input logic [1:0] m, input logic [3:0] r, input logic b,
                          input logic [15:0] x, input logic [15:0] w, input string tag);
        exp_t e;
        logic [15:0] loc, cont;
        int lat, rd0, wr0;
        loc  = w + {11'd0, r, 1'b0};
        cont = mem[loc[8:1]];
        e.tag = tag;
        e.is_reg = (m == 2'b00);
        e.ext_used = (m == 2'b10);
        case (m)
            2'b00: begin e.ea = loc; lat = 1; end
            2'b01: begin e.ea = cont; lat = 3; end
            2'b10: begin
                if (r == 4'd0) begin e.ea = x; lat = 1; end
                else begin e.ea = x + cont; lat = 3; end
            end
            default: begin e.ea = cont; lat = 4; end
        endcase
        e.cyc = ncyc + lat;
        sb.push_back(e);
        rd0 = nrd; wr0 = nwr;
        mode = m; reg_num = r; byte_op = b; ext_word = x; wp = w; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (lat + 2) @(negedge clk);
        chk(nrd - rd0 == (lat == 1 ? 0 : 1), tag, "read count", nrd - rd0, lat == 1 ? 0 : 1);
        chk(nwr - wr0 == (m == 2'b11 ? 1 : 0), tag, "write count", nwr - wr0, m == 2'b11 ? 1 : 0);
        if (m == 2'b11) begin
            logic [15:0] nv;
            nv = cont + (b ? 16'd1 : 16'd2);
            chk(mem[loc[8:1]] == nv, tag, "written back", int'(mem[loc[8:1]]), int'(nv));
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h1000 + 16'(i * 7);
        mem[8'h85] = 16'hFFF0;
        mem[8'h86] = 16'hFFFF;
        mem[8'h87] = 16'hFFFF;
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R8", "done", int'(done), 0);
        chk(busy == 1'b0, "R8", "busy", int'(busy), 0);
        chk(mem_req == 1'b0, "R8", "mem_req", int'(mem_req), 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_op(2'b00, 4'd3, 1'b0, 16'h0, 16'h0100, "R1");
        run_op(2'b00, 4'd15, 1'b1, 16'h5555, 16'h0200, "R1");
        run_op(2'b00, 4'd2, 1'b0, 16'h0, 16'hFFFE, "R6");
        run_op(2'b01, 4'd5, 1'b0, 16'h0, 16'h0100, "R2");
        run_op(2'b01, 4'd0, 1'b1, 16'hABCD, 16'h0040, "R2");
        run_op(2'b10, 4'd4, 1'b0, 16'h0300, 16'h0100, "R3");
        run_op(2'b10, 4'd2, 1'b0, 16'h0020, 16'h0106, "R6");
        run_op(2'b10, 4'd0, 1'b0, 16'h8642, 16'h0100, "R4");
        run_op(2'b11, 4'd6, 1'b0, 16'h0, 16'h0100, "R5");
        run_op(2'b11, 4'd6, 1'b1, 16'h0, 16'h0100, "R5");
        run_op(2'b11, 4'd0, 1'b1, 16'h0, 16'h010E, "R6");
        run_op(2'b11, 4'd0, 1'b0, 16'h0, 16'h010C, "R6");

        // start while busy must be ignored
        begin
            exp_t e;
            int rd0, wr0;
            e.tag = "R7";
            e.is_reg = 1'b0;
            e.ext_used = 1'b0;
            e.ea = mem[8'h85];
            e.cyc = ncyc + 3;
            sb.push_back(e);
            rd0 = nrd; wr0 = nwr;
            mode = 2'b01; reg_num = 4'd1; wp = 16'h0108; start = 1'b1;
            @(negedge clk);
            chk(busy == 1'b1, "R7", "busy", int'(busy), 1);
            mode = 2'b11; reg_num = 4'd7; byte_op = 1'b0; wp = 16'h0000;
            @(negedge clk);
            mode = 2'b00;
            @(negedge clk);
            start = 1'b0;
            repeat (6) @(negedge clk);
            chk(extra_done == 0, "R7", "extra done", extra_done, 0);
            chk(nrd - rd0 == 1, "R7", "read count", nrd - rd0, 1);
            chk(nwr - wr0 == 0, "R7", "write count", nwr - wr0, 0);
            chk(mem_req == 1'b0, "R7", "mem_req idle", int'(mem_req), 0);
        end

        chk(sb.size() == 0, "R7", "pending results", sb.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule